// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a general-purpose I/O port of up to 32 lines sitting on a simple 32-bit register bus. Each line has a direction bit and an output value, and software reads the pin level back through a two-flop synchroniser. Any line can also raise an interrupt. A polarity bit and an edge bit per line choose between level and edge sensing and pick the active sense. A per-line mask gates the interrupt.

Each line carries a one-byte routing entry that steers its interrupt onto one of several shared interrupt wires, or onto none. Every wire is the OR of all unmasked, triggered lines routed to it. The interrupt wires are registered, so they are free of glitches. The bus port uses byte addresses and returns read data in the same cycle.

Top module: `gpio_irq_router`

## Requirements
- R1: The parameter `NLINES` sets the number of lines when it is between 1 and 32; any other value gives 32 lines. Register bits above the last line read 0 and ignore writes.
- R2: Word offsets are: pin data 0x00 (read-only), output value 0x04, direction 0x08, mask 0x0C, polarity 0x10, edge select 0x14, and a spare 0x18 that reads back what was written and affects nothing. Routing words start at 0x20. Bit n of each per-line register belongs to line n. Reads return the data in the same cycle, writes take effect at the clock edge that samples them, and any other address reads 0.
- R3: `pinOe` follows the direction register and `pinOut` follows the output register. A direction bit of 1 means the line is an output. After reset, direction, output, mask, polarity, edge select and the spare register are all 0.
- R4: The pin data register shows `pinIn` through two flops. A pin change made before clock edge n can be read after edge n+1. A write to offset 0x00 has no effect.
- R5: The polarity bit p and the edge bit e select the trigger for each line as follows: p=0,e=0 is level low; p=1,e=0 is level high; p=0,e=1 is a falling edge; p=1,e=1 is a rising edge.
- R6: A level-triggered, unmasked line holds its interrupt wire high for as long as the qualifying level persists. The wire changes three clock edges after the pin changes.
- R7: An edge-triggered line raises its wire for exactly one cycle per qualifying transition, three edges after the pin change. A transition of the opposite sense produces nothing.
- R8: A line with mask bit 0 never drives a wire. After a write that clears the mask bit, the wire falls one edge later than the write.
- R9: Routing word 0x20+4w holds lines 4w to 4w+3, with line 4w+j in bits [31-8j:24-8j] (big-endian order). In each byte, bit 7 = 1 means the line is unconnected, and bits 6:0 give the wire index. An index of `NUM_IRQ` or more also leaves the line unconnected. The bytes reset to 0x80. A routing change reaches the wire one edge after the write.
- R10: Each interrupt wire is the OR of all unmasked, triggered lines routed to it, and a line affects no wire other than its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, same cycle |
| pinIn | input | LINES | Pin levels from pads |
| pinOut | output | LINES | Output values to pads |
| pinOe | output | LINES | Output enables to pads |
| irqOut | output | NUM_IRQ | Routed interrupt wires |

## Verification
Configuration written over the bus is visible at the next edge. Pin data is due two edges after a pin change, and an interrupt wire moves three edges after a pin change but only one edge after a mask or routing write. The bench drives and samples on falling clock edges and counts rising edges between each stimulus and its check. Edge pulses are checked by counting the high samples over a window longer than the latency, so both a missing pulse and a stretched pulse are caught.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_OUT, SEL_DIR, SEL_MASK,
    SEL_POL, SEL_EDGE, SEL_SPARE, SEL_MAP
  } regSel_e;

  typedef struct packed {
    logic       wrOut;
    logic       wrDir;
    logic       wrMask;
    logic       wrPol;
    logic       wrEdge;
    logic       wrSpare;
    logic       wrMap;
    logic [2:0] mapWord;
    regSel_e    rdSel;
  } busStrobe_t;

endpackage

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAP_WORDS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output busStrobe_t        strobe
);

  localparam int WORD_W   = ADDR_W - 2;
  localparam int MAP_BASE = 8;

  logic [WORD_W-1:0] wordSel;
  int                wordIdx;

  assign wordSel = busAddr[ADDR_W-1:2];
  assign wordIdx = int'(wordSel);

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    if (wordIdx < 7) begin
      case (wordIdx)
        0: strobe.rdSel = SEL_DATA;
        1: begin strobe.rdSel = SEL_OUT;   strobe.wrOut   = busWrEn; end
        2: begin strobe.rdSel = SEL_DIR;   strobe.wrDir   = busWrEn; end
        3: begin strobe.rdSel = SEL_MASK;  strobe.wrMask  = busWrEn; end
        4: begin strobe.rdSel = SEL_POL;   strobe.wrPol   = busWrEn; end
        5: begin strobe.rdSel = SEL_EDGE;  strobe.wrEdge  = busWrEn; end
        default: begin strobe.rdSel = SEL_SPARE; strobe.wrSpare = busWrEn; end
      endcase
    end else if (wordIdx >= MAP_BASE && wordIdx < MAP_BASE + MAP_WORDS) begin
      strobe.rdSel   = SEL_MAP;
      strobe.wrMap   = busWrEn;
      strobe.mapWord = 3'(wordIdx - MAP_BASE);
    end
  end

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrOut, strobe.wrDir, strobe.wrMask, strobe.wrPol,
              strobe.wrEdge, strobe.wrSpare, strobe.wrMap}));

  // R4
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> !(strobe.wrOut || strobe.wrDir || strobe.wrMask || strobe.wrPol ||
                   strobe.wrEdge || strobe.wrSpare || strobe.wrMap));

endmodule

// File: rtl/gpio_irq_dp.sv
`timescale 1ns/1ps
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int LINES     = 8,
  parameter int NUM_IRQ   = 4,
  parameter int MAP_WORDS = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrobe_t         strobe,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [LINES-1:0]   pinIn,
  output logic [LINES-1:0]   pinOut,
  output logic [LINES-1:0]   pinOe,
  output logic [NUM_IRQ-1:0] irqOut
);

  localparam int MAP_BITS = MAP_WORDS * 32;

  logic [LINES-1:0] outReg, dirReg, maskReg, polReg, edgeReg, spareReg;
  logic [LINES-1:0] syncA, syncB, syncPrev;
  logic [LINES-1:0] riseEv, fallEv, levelHit, edgeHit, trig;
  logic [7:0]       mapByte [LINES];
  logic [MAP_BITS-1:0] mapFlat;
  logic [LINES-1:0] routeHit [NUM_IRQ];
  logic [NUM_IRQ-1:0] irqNext;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '0;
      maskReg  <= '0;
      polReg   <= '0;
      edgeReg  <= '0;
      spareReg <= '0;
    end else begin
      if (strobe.wrOut)   outReg   <= wrData[LINES-1:0];
      if (strobe.wrDir)   dirReg   <= wrData[LINES-1:0];
      if (strobe.wrMask)  maskReg  <= wrData[LINES-1:0];
      if (strobe.wrPol)   polReg   <= wrData[LINES-1:0];
      if (strobe.wrEdge)  edgeReg  <= wrData[LINES-1:0];
      if (strobe.wrSpare) spareReg <= wrData[LINES-1:0];
    end
  end

  // routing bytes, one per line, big-endian within a word
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_map
      localparam int WORD = i / 4;
      localparam int MSB  = 31 - 8 * (i % 4);
      always_ff @(posedge clk) begin
        if (!rstN)
          mapByte[i] <= 8'h80;
        else if (strobe.wrMap && strobe.mapWord == 3'(WORD))
          mapByte[i] <= wrData[MSB -: 8];
      end
      assign mapFlat[WORD*32 + MSB -: 8] = mapByte[i];
    end
    for (genvar i = LINES; i < MAP_WORDS * 4; i++) begin : g_map_pad
      assign mapFlat[(i/4)*32 + 31 - 8*(i%4) -: 8] = 8'h00;
    end
  endgenerate

  // two-flop synchroniser plus history flop for edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  // trigger selection
  assign riseEv   = syncB & ~syncPrev;
  assign fallEv   = ~syncB & syncPrev;
  assign levelHit = ~edgeReg & ~(syncB ^ polReg);
  assign edgeHit  = edgeReg & ((polReg & riseEv) | (~polReg & fallEv));
  assign trig     = (levelHit | edgeHit) & maskReg;

  // routing onto shared wires
  generate
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
      for (genvar i = 0; i < LINES; i++) begin : g_line
        assign routeHit[k][i] = !mapByte[i][7] && (mapByte[i][6:0] == 7'(k));
      end
      assign irqNext[k] = |(trig & routeHit[k]);

      // R8
      route_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
        irqOut[k] |-> $past(|(routeHit[k] & maskReg)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= irqNext;
  end

  assign pinOut = outReg;
  assign pinOe  = dirReg;

  // read mux
  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      SEL_DATA:  rdData = 32'(syncB);
      SEL_OUT:   rdData = 32'(outReg);
      SEL_DIR:   rdData = 32'(dirReg);
      SEL_MASK:  rdData = 32'(maskReg);
      SEL_POL:   rdData = 32'(polReg);
      SEL_EDGE:  rdData = 32'(edgeReg);
      SEL_SPARE: rdData = 32'(spareReg);
      SEL_MAP: begin
        for (int w = 0; w < MAP_WORDS; w++)
          if (strobe.mapWord == 3'(w)) rdData = mapFlat[w*32 +: 32];
      end
      default:   rdData = '0;
    endcase
  end

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> $past(|maskReg));

  // R7
  generate
    for (genvar i = 0; i < LINES; i++) begin : g_edge_chk
      edge_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        riseEv[i] |=> !riseEv[i]);
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NLINES  = 8,
  parameter int NUM_IRQ = 4,
  parameter int ADDR_W  = 8,
  localparam int LINES  = (NLINES < 1 || NLINES > 32) ? 32 : NLINES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [LINES-1:0]   pinIn,
  output logic [LINES-1:0]   pinOut,
  output logic [LINES-1:0]   pinOe,
  output logic [NUM_IRQ-1:0] irqOut
);

  localparam int MAP_WORDS = (LINES + 3) / 4;

  busStrobe_t strobe;

  gpio_irq_ctrl #(.ADDR_W(ADDR_W), .MAP_WORDS(MAP_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  gpio_irq_dp #(.LINES(LINES), .NUM_IRQ(NUM_IRQ), .MAP_WORDS(MAP_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData), .rdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

endmodule

// File: tb/sim_gpio_irq_router.sv
`timescale 1ns/1ps
module sim_gpio_irq_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] rd0, rd1;
  logic [7:0]  pins = '0;
  logic [7:0]  pinOut0, pinOe0;
  logic [3:0]  irq0;
  logic [31:0] pinOut1, pinOe1;
  logic [3:0]  irq1;

  int checks = 0;
  int errors = 0;
  logic [7:0] polV = '0, edgeV = '0;
  logic [31:0] rdA, rdB;

  always #2.5 clk = ~clk;

  gpio_irq_router #(.NLINES(8), .NUM_IRQ(4), .ADDR_W(8)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rd0), .pinIn(pins),
    .pinOut(pinOut0), .pinOe(pinOe0), .irqOut(irq0)
  );

  gpio_irq_router #(.NLINES(40), .NUM_IRQ(4), .ADDR_W(8)) u1 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(rd1), .pinIn(32'h0),
    .pinOut(pinOut1), .pinOe(pinOe1), .irqOut(irq1)
  );

  // {addr, write data, expected read on u0}
  localparam logic [71:0] VEC [11] = '{
    {8'h04, 32'hA5A5A5A5, 32'h000000A5},
    {8'h08, 32'hFFFFFF0F, 32'h0000000F},
    {8'h0C, 32'h12345678, 32'h00000078},
    {8'h10, 32'hFFFFFFFF, 32'h000000FF},
    {8'h14, 32'h00000055, 32'h00000055},
    {8'h18, 32'hDEADBEEF, 32'h000000EF},
    {8'h1C, 32'h11111111, 32'h00000000},
    {8'h00, 32'hFFFFFFFF, 32'h00000000},
    {8'h20, 32'h01028304, 32'h01028304},
    {8'h24, 32'h7F000180, 32'h7F000180},
    {8'h28, 32'hFFFFFFFF, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1;
    rdA = rd0; rdB = rd1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cyc(3);
    rstN = 1'b1;
    polV = '0; edgeV = '0;
  endtask

  task automatic countIrq(input int bitSel, input int win, output int cnt);
    cnt = 0;
    for (int c = 0; c < win; c++) begin
      cyc(1);
      if (irq0[bitSel]) cnt++;
    end
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    doReset();

    // R2 / R9 / R4 register table
    for (int i = 0; i < 11; i++) begin
      busWrite(VEC[i][71:64], VEC[i][63:32]);
      busRead(VEC[i][71:64]);
      check($sformatf("R2 table %0d", i), rdA, VEC[i][31:0]);
    end

    // R1: out-of-range line count gives 32 lines; u0 trims to 8
    busWrite(8'h08, 32'hFFFFFFFF);
    busRead(8'h08);
    check("R1 u0 dir width", rdA, 32'h000000FF);
    check("R1 u1 dir width", rdB, 32'hFFFFFFFF);
    busWrite(8'h3C, 32'h01020304);
    busRead(8'h3C);
    check("R1 u1 last map word", rdB, 32'h01020304);
    check("R1 u0 map beyond lines", rdA, 32'h0);

    // R3 reset state
    doReset();
    cyc(1);
    check("R3 reset pinOe", 32'(pinOe0), 32'h0);
    check("R3 reset pinOut", 32'(pinOut0), 32'h0);
    check("R3 reset irqOut", 32'(irq0), 32'h0);
    busRead(8'h0C);
    check("R3 reset mask", rdA, 32'h0);
    busRead(8'h24);
    check("R9 reset map", rdA, 32'h80808080);

    // R3 direction and output
    busWrite(8'h04, 32'h0000003C);
    busWrite(8'h08, 32'h000000F0);
    check("R3 pinOut", 32'(pinOut0), 32'h3C);
    check("R3 pinOe", 32'(pinOe0), 32'hF0);

    // R4 synchroniser latency
    @(negedge clk);
    pins = 8'h5A;
    busRead(8'h00);
    check("R4 data after one edge", rdA, 32'h0);
    busRead(8'h00);
    check("R4 data after two edges", rdA, 32'h5A);
    pins = 8'h00;
    cyc(4);

    // R9 routing: l0->0, l1->1, l2->1, l3 off, l4 idx 9, l5->2, l6->3, l7 off
    busWrite(8'h20, 32'h00010180);
    busWrite(8'h24, 32'h09020380);

    // R6 level high on line 0
    polV = 8'h01;
    busWrite(8'h10, 32'(polV));
    busWrite(8'h0C, 32'h01);
    cyc(2);
    check("R6 idle low pin", 32'(irq0), 32'h0);
    pins[0] = 1'b1;
    cyc(2);
    check("R6 before latency", 32'(irq0[0]), 32'h0);
    cyc(1);
    check("R6 at latency", 32'(irq0[0]), 32'h1);
    cyc(5);
    check("R6 held", 32'(irq0), 32'h1);
    pins[0] = 1'b0;
    cyc(3);
    check("R6 released", 32'(irq0[0]), 32'h0);

    // R8 mask clear
    pins[0] = 1'b1;
    cyc(3);
    busWrite(8'h0C, 32'h00);
    check("R8 same edge as write", 32'(irq0[0]), 32'h1);
    cyc(1);
    check("R8 masked", 32'(irq0[0]), 32'h0);
    pins[0] = 1'b0;
    cyc(3);

    // R5 level low on line 5 -> wire 2
    busWrite(8'h0C, 32'h20);
    check("R5 level low before", 32'(irq0[2]), 32'h0);
    cyc(1);
    check("R5 level low fires", 32'(irq0[2]), 32'h1);
    pins[5] = 1'b1;
    cyc(3);
    check("R5 level low clears", 32'(irq0[2]), 32'h0);
    busWrite(8'h0C, 32'h00);
    pins[5] = 1'b0;
    cyc(3);

    // R7 rising edge on line 6 -> wire 3
    polV = 8'h40; edgeV = 8'h40;
    busWrite(8'h10, 32'(polV));
    busWrite(8'h14, 32'(edgeV));
    busWrite(8'h0C, 32'h40);
    pins[6] = 1'b1;
    cyc(2);
    check("R7 rise before latency", 32'(irq0[3]), 32'h0);
    cyc(1);
    check("R7 rise at latency", 32'(irq0[3]), 32'h1);
    cyc(1);
    check("R7 rise one cycle", 32'(irq0[3]), 32'h0);
    pins[6] = 1'b0;
    countIrq(3, 8, cnt);
    check("R7 rising ignores fall", 32'(cnt), 32'h0);
    polV = 8'h00;
    busWrite(8'h10, 32'(polV));
    pins[6] = 1'b1;
    countIrq(3, 8, cnt);
    check("R5 falling ignores rise", 32'(cnt), 32'h0);
    pins[6] = 1'b0;
    countIrq(3, 8, cnt);
    check("R7 falling single pulse", 32'(cnt), 32'h1);
    busWrite(8'h0C, 32'h00);
    edgeV = 8'h00;
    busWrite(8'h14, 32'(edgeV));

    // R10 shared wire, lines 1 and 2 -> wire 1, level high
    polV = 8'h06;
    busWrite(8'h10, 32'(polV));
    busWrite(8'h0C, 32'h06);
    pins[1] = 1'b1;
    cyc(3);
    check("R10 line1 on wire1", 32'(irq0), 32'h2);
    pins[1] = 1'b0; pins[2] = 1'b1;
    cyc(3);
    check("R10 line2 on wire1", 32'(irq0), 32'h2);
    pins[2] = 1'b0;
    cyc(3);
    check("R10 wire1 idle", 32'(irq0), 32'h0);
    busWrite(8'h0C, 32'h00);

    // R9 unconnected lines 3 (bit7) and 4 (index 9)
    polV = 8'h18;
    busWrite(8'h10, 32'(polV));
    pins[3] = 1'b1; pins[4] = 1'b1;
    cyc(3);
    busWrite(8'h0C, 32'h18);
    cyc(4);
    check("R9 unconnected silent", 32'(irq0), 32'h0);
    busWrite(8'h24, 32'h00020380);
    check("R9 remap same edge", 32'(irq0), 32'h0);
    cyc(1);
    check("R9 remap line4 to wire0", 32'(irq0), 32'h1);
    busWrite(8'h0C, 32'h00);
    pins = '0;
    cyc(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule